// File: doc/BRIEF.md
# Stretchable External Data Memory Bus Controller

This block runs one bus cycle to an off-chip data memory for each read or write request from a small 8-bit processor core. It drives an address-latch strobe, active-low read and write strobes, the low address byte and write data on a shared 8-bit bus, and the high address byte on its own port. It returns the read data with a one-clock completion pulse. A timing register sets the length of each part of the cycle in system clocks. The fields are the address-latch pulse length, the command setup/hold length and the command strobe length. A mode bit can also remove the address phase altogether.

A separate select input keeps a 1024-byte on-chip RAM in use for the lowest addresses. When that input is low, accesses to those addresses go to the internal RAM and finish on the next clock with no external strobe. The timing register is sampled when a request is accepted. A write to it during a cycle only affects the following cycle.

Top module: `xmem_stretch_ctrl`

## Requirements
- R1: After reset the timing register reads 0x00, `busy` and `done` are 0, `ale` is 0, `rd_n` and `wr_n` are 1, and `ad_oe` is 0.
- R2: The timing register byte holds the address-mode bit in bit 7 (1 = no address phase), a reserved bit 6, the latch width L in bits 5:4, the setup/hold bit H in bit 3 and the strobe width P in bits 2:0. Bit 6 always reads back 0, so writing 0xFF reads back 0xBF.
- R3: In multiplexed mode (bit 7 = 0), `ale` is high for the first L+1 clocks after acceptance, then low for L+1 clocks. The low address byte is on `ad_out` with `ad_oe` = 1 throughout both parts.
- R4: A setup time of H+1 clocks comes before the command strobe, and a hold time of H+1 clocks follows it.
- R5: Exactly one of `rd_n` and `wr_n` is low for P+1 consecutive clocks per external cycle. The one that is low is selected by `req_write`.
- R6: With bit 7 = 1, `ale` never rises and the latch width field has no effect. The setup phase starts on the first clock after acceptance.
- R7: During a write, `ad_oe` = 1 and `ad_out` carries the write data from the first setup clock through the last hold clock.
- R8: During a read, `ad_oe` = 0 from the first setup clock to the end of the cycle. `rd_data` carries the value that `ad_in` had on the last strobe clock.
- R9: `done` is high for exactly one clock, 2A+2(H+1)+P+2 clocks after acceptance, where A is L+1 in multiplexed mode and 0 otherwise. `rd_data` is valid in that clock.
- R10: With `ext_only` = 0, an address below 1024 uses the on-chip RAM. No strobe is driven, and `done` (with read data) follows one clock after acceptance. Address 1024 and above still make an external cycle.
- R11: With `ext_only` = 1, every address, including those below 1024, makes an external cycle.
- R12: A request is accepted only while `busy` is 0, and a request made while busy is dropped. A timing register write during a cycle does not change that cycle.
- R13: `rd_n` and `wr_n` are never low together, and neither is low while `busy` is 0.
- R14: `addr_hi` holds the high byte of the accepted address for the whole cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Write strobe for the timing register |
| cfg_wr_data | input | 8 | Timing register write value |
| cfg_rd_data | output | 8 | Timing register read value |
| ext_only | input | 1 | 1 = on-chip RAM disabled, all accesses go off-chip |
| req_valid | input | 1 | Access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| busy | output | 1 | Cycle in progress; requests are ignored |
| done | output | 1 | One-clock completion pulse |
| rd_data | output | 8 | Read result, valid with `done` |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Active-low read strobe |
| wr_n | output | 1 | Active-low write strobe |
| addr_hi | output | 8 | High address byte |
| ad_out | output | 8 | Shared bus drive value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus input value |

## Verification
The assertions check, on every clock, the rules that do not depend on timing. The two strobes never overlap, and neither is active outside a cycle. The bus is driven during write strobes and released during read strobes. `ale` stays quiet in the no-address mode, `done` lasts one clock, and `addr_hi` is stable. A counter also checks each strobe length against the latched width, and on-chip hits must finish on the next clock. Only the bench scenarios show the exact clock of each phase boundary for several timing settings. They also show that read data comes from the last strobe clock and not an earlier one, and that the RAM window is routed correctly. Finally, they show that requests and register writes made mid-cycle are dropped or deferred.

// File: rtl/xmem_pkg.sv
package xmem_pkg;

    localparam int CFG_W = 8;
    localparam int CNT_W = 3;

    // Timing register layout; field positions are software-visible.
    typedef struct packed {
        logic       no_addr;   // 1: skip the address phase
        logic       rsvd;      // always 0
        logic [1:0] ale_w;     // latch high/low length - 1
        logic       setup2;    // setup/hold length - 1
        logic [2:0] stb_w;     // command strobe length - 1
    } xm_cfg_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ALE_HI,
        ST_ALE_LO,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } xm_state_e;

    // Counter preload values: phase length minus one.
    function automatic logic [CNT_W-1:0] ale_load(input xm_cfg_t c);
        return CNT_W'(c.ale_w);
    endfunction

    function automatic logic [CNT_W-1:0] sh_load(input xm_cfg_t c);
        return CNT_W'(c.setup2);
    endfunction

    function automatic logic [CNT_W-1:0] stb_load(input xm_cfg_t c);
        return CNT_W'(c.stb_w);
    endfunction

endpackage

// File: rtl/xmem_cfg_reg.sv
module xmem_cfg_reg
    import xmem_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output xm_cfg_t          cfg_o,
    output logic [CFG_W-1:0] rd_data
);

    xm_cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            cfg_d      = xm_cfg_t'(wr_data);
            cfg_d.rsvd = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_o   = cfg_q;
    assign rd_data = CFG_W'(cfg_q);

endmodule

// File: rtl/xmem_local_ram.sv
module xmem_local_ram #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 1024,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              en,
    input  logic              we,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_q;

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) begin
                mem[addr] <= wdata;
                rdata_q   <= wdata;
            end else begin
                rdata_q   <= mem[addr];
            end
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/xmem_bus_seq.sv
module xmem_bus_seq
    import xmem_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    localparam int HI_W  = ADDR_W - DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_local,
    input  xm_cfg_t           cfg_i,
    input  logic [DATA_W-1:0] ad_in,
    output logic              busy,
    output logic              done,
    output logic              local_o,
    output logic [DATA_W-1:0] ext_rdata,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);

    typedef struct packed {
        xm_state_e         st;
        logic [CNT_W-1:0]  cnt;
        xm_cfg_t           cfg;
        logic              wr;
        logic              loc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
    } seq_t;

    seq_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.cfg   = cfg_i;
                    r_d.wr    = req_write;
                    r_d.addr  = req_addr;
                    r_d.wdata = req_wdata;
                    r_d.loc   = req_local;
                    if (req_local) begin
                        r_d.st  = ST_DONE;
                        r_d.cnt = '0;
                    end else if (cfg_i.no_addr) begin
                        r_d.st  = ST_SETUP;
                        r_d.cnt = sh_load(cfg_i);
                    end else begin
                        r_d.st  = ST_ALE_HI;
                        r_d.cnt = ale_load(cfg_i);
                    end
                end
            end
            ST_ALE_HI: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.st  = ST_ALE_LO;
                    r_d.cnt = ale_load(r_q.cfg);
                end
            end
            ST_ALE_LO: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.st  = ST_SETUP;
                    r_d.cnt = sh_load(r_q.cfg);
                end
            end
            ST_SETUP: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.st  = ST_STROBE;
                    r_d.cnt = stb_load(r_q.cfg);
                end
            end
            ST_STROBE: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    if (!r_q.wr) begin
                        r_d.rdata = ad_in;
                    end
                    r_d.st  = ST_HOLD;
                    r_d.cnt = sh_load(r_q.cfg);
                end
            end
            ST_HOLD: begin
                if (r_q.cnt != '0) begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end else begin
                    r_d.st  = ST_DONE;
                end
            end
            ST_DONE: begin
                r_d.st = ST_IDLE;
            end
            default: begin
                r_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    logic addr_ph, data_ph;
    assign addr_ph   = (r_q.st == ST_ALE_HI) || (r_q.st == ST_ALE_LO);
    assign data_ph   = (r_q.st == ST_SETUP) || (r_q.st == ST_STROBE) || (r_q.st == ST_HOLD);

    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_DONE);
    assign local_o   = r_q.loc;
    assign ext_rdata = r_q.rdata;
    assign ale       = (r_q.st == ST_ALE_HI);
    assign rd_n      = !((r_q.st == ST_STROBE) && !r_q.wr);
    assign wr_n      = !((r_q.st == ST_STROBE) && r_q.wr);
    assign addr_hi   = r_q.addr[ADDR_W-1:DATA_W];
    assign ad_oe     = addr_ph || (data_ph && r_q.wr);
    assign ad_out    = addr_ph ? r_q.addr[DATA_W-1:0] : r_q.wdata;

    // Strobe run length counter for the width check.
    logic       stb_act;
    logic [3:0] stb_run_q;
    assign stb_act = !rd_n || !wr_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_run_q <= '0;
        end else if (stb_act) begin
            stb_run_q <= stb_run_q + 4'd1;
        end else begin
            stb_run_q <= '0;
        end
    end

    assert_strobe_excl_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_strobe_in_cycle_R13: assert property (@(posedge clk) disable iff (!rst_n)
        stb_act |-> busy);

    assert_strobe_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(stb_act) |-> (stb_run_q == ({1'b0, r_q.cfg.stb_w} + 4'd1)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_wr_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> (ad_oe && (ad_out == r_q.wdata)));

    assert_rd_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);

    assert_no_ale_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && r_q.cfg.no_addr) |-> !ale);

    assert_hi_stable_R14: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(addr_hi));

endmodule

// File: rtl/xmem_stretch_ctrl.sv
module xmem_stretch_ctrl
    import xmem_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 8,
    parameter int LOCAL_DEPTH = 1024,
    localparam int HI_W       = ADDR_W - DATA_W,
    localparam int LOC_AW     = $clog2(LOCAL_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              ext_only,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rd_data,
    output logic              ale,
    output logic              rd_n,
    output logic              wr_n,
    output logic [HI_W-1:0]   addr_hi,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    input  logic [DATA_W-1:0] ad_in
);

    xm_cfg_t           cfg;
    logic              local_hit;
    logic              accept;
    logic              ram_en;
    logic              seq_local;
    logic [DATA_W-1:0] ram_rdata;
    logic [DATA_W-1:0] ext_rdata;

    assign local_hit = !ext_only && (32'(req_addr) < LOCAL_DEPTH);
    assign accept    = req_valid && !busy;
    assign ram_en    = accept && local_hit;

    xmem_cfg_reg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg),
        .rd_data (cfg_rd_data)
    );

    xmem_local_ram #(
        .DATA_W (DATA_W),
        .DEPTH  (LOCAL_DEPTH)
    ) u_ram (
        .clk   (clk),
        .en    (ram_en),
        .we    (req_write),
        .addr  (req_addr[LOC_AW-1:0]),
        .wdata (req_wdata),
        .rdata (ram_rdata)
    );

    xmem_bus_seq #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_local (local_hit),
        .cfg_i     (cfg),
        .ad_in     (ad_in),
        .busy      (busy),
        .done      (done),
        .local_o   (seq_local),
        .ext_rdata (ext_rdata),
        .ale       (ale),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr_hi   (addr_hi),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe)
    );

    assign rd_data = seq_local ? ram_rdata : ext_rdata;

    assert_local_next_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && local_hit) |=> (done && rd_n && wr_n && !ale));

endmodule

// File: tb/xmem_stretch_ctrl_tb.sv
`timescale 1ns/1ps
module xmem_stretch_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_data = '0;
    logic [7:0]  cfg_rd_data;
    logic        ext_only = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        busy, done, ale, rd_n, wr_n, ad_oe;
    logic [7:0]  rd_data, addr_hi, ad_out;
    logic [7:0]  ad_in = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #4 clk = ~clk;

    xmem_stretch_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
        .cfg_rd_data(cfg_rd_data), .ext_only(ext_only), .req_valid(req_valid),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .rd_data(rd_data), .ale(ale), .rd_n(rd_n),
        .wr_n(wr_n), .addr_hi(addr_hi), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [7:0] v);
        @(negedge clk);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    // One external or local access; all phase boundaries compared per clock.
    task automatic run_acc(input logic [7:0] cfgv, input bit wr, input logic [15:0] addr,
                           input logic [7:0] data, input bit expect_local,
                           input bit mid_req, input bit mid_cfg);
        int a, s, w, k_start, k_end, h_end, d_idx;
        int bad_ale, bad_stb, bad_done, bad_bus, bad_hi, n_done, n_stb;
        bit mux;
        logic [7:0] got_rd;
        write_cfg(cfgv);
        mux   = !cfgv[7];
        a     = mux ? (int'(cfgv[5:4]) + 1) : 0;
        s     = int'(cfgv[3]) + 1;
        w     = int'(cfgv[2:0]) + 1;
        k_start = 2*a + s + 1;
        k_end   = 2*a + s + w;
        h_end   = k_end + s;
        d_idx   = expect_local ? 1 : h_end + 1;
        bad_ale = 0; bad_stb = 0; bad_done = 0; bad_bus = 0; bad_hi = 0;
        n_done = 0; n_stb = 0; got_rd = '0;
        req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0;
        for (int idx = 1; idx <= d_idx + 2; idx++) begin
            bit e_stb, e_ale, e_done;
            if (idx > 1) @(negedge clk);
            ad_in = (idx == k_end) ? data : ~data;
            if (mid_req) begin
                req_valid = (idx == 2 || idx == 3);
                req_addr  = addr ^ 16'h0100;
            end
            if (mid_cfg) begin
                cfg_wr_en   = (idx == 2);
                cfg_wr_data = 8'h00;
            end
            e_stb  = !expect_local && idx >= k_start && idx <= k_end;
            e_ale  = !expect_local && idx <= a;
            e_done = (idx == d_idx);
            if (ale !== e_ale && bad_ale == 0) bad_ale = idx;
            if ((rd_n !== !(e_stb && !wr)) || (wr_n !== !(e_stb && wr))) begin
                if (bad_stb == 0) bad_stb = idx;
            end
            if (!rd_n || !wr_n) n_stb++;
            if (done !== e_done && bad_done == 0) bad_done = idx;
            if (done) begin n_done++; got_rd = rd_data; end
            if (!expect_local) begin
                if (mux && idx <= 2*a && !(ad_oe && ad_out == addr[7:0]) && bad_bus == 0) bad_bus = idx;
                if (idx > 2*a && idx <= h_end) begin
                    if (wr && !(ad_oe && ad_out == data) && bad_bus == 0) bad_bus = idx;
                    if (!wr && ad_oe && bad_bus == 0) bad_bus = idx;
                end
            end
            if (idx <= d_idx && addr_hi !== addr[15:8] && bad_hi == 0) bad_hi = idx;
            if (idx == d_idx + 1 && busy) bad_done = idx;
        end
        req_valid = 1'b0; cfg_wr_en = 1'b0;
        check(bad_ale == 0, "R3/R6 ale timing, first bad clock", bad_ale, 0);
        check(bad_stb == 0, "R4/R5 strobe timing, first bad clock", bad_stb, 0);
        check(bad_done == 0 && n_done == 1, "R9 done timing, first bad clock", bad_done, 0);
        check(bad_hi == 0, "R14 addr_hi, first bad clock", bad_hi, 0);
        if (!expect_local)
            check(bad_bus == 0, wr ? "R7 write bus drive" : "R8 read bus release", bad_bus, 0);
        if (!wr)
            check(got_rd == data, expect_local ? "R10 local read data" : "R8 sampled read data",
                  int'(got_rd), int'(data));
        if (expect_local)
            check(n_stb == 0, "R10 no strobe on local access", n_stb, 0);
        else
            check(n_stb == w, "R10/R11 external strobe clocks", n_stb, w);
        if (mid_req)
            check(n_done == 1, "R12 request while busy dropped", n_done, 1);
    endtask

    task automatic t_reset();
        check(cfg_rd_data == 8'h00, "R1 cfg reset", int'(cfg_rd_data), 0);
        check(!busy && !done && !ale && rd_n && wr_n && !ad_oe, "R1 idle outputs",
              int'({busy, done, ale, rd_n, wr_n, ad_oe}), int'(6'b000110));
    endtask

    task automatic t_cfg();
        write_cfg(8'hFF);
        check(cfg_rd_data == 8'hBF, "R2 reserved bit reads 0", int'(cfg_rd_data), 8'hBF);
        write_cfg(8'h5A);
        check(cfg_rd_data == 8'h1A, "R2 field readback", int'(cfg_rd_data), 8'h1A);
    endtask

    task automatic t_mux_min();   run_acc(8'h00, 1'b1, 16'h1234, 8'h5C, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_mux_max();   run_acc(8'h3F, 1'b0, 16'hBE21, 8'h93, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_mux_mix();   run_acc(8'h29, 1'b0, 16'h7777, 8'h0F, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_nomux();     run_acc(8'hB5, 1'b1, 16'hA0C3, 8'hE1, 1'b0, 1'b0, 1'b0); endtask
    task automatic t_nomux_rd();  run_acc(8'h88, 1'b0, 16'h4411, 8'h66, 1'b0, 1'b0, 1'b0); endtask

    task automatic t_local();
        ext_only = 1'b0;
        run_acc(8'h3F, 1'b1, 16'h03FF, 8'hA5, 1'b1, 1'b0, 1'b0);
        run_acc(8'h3F, 1'b0, 16'h03FF, 8'hA5, 1'b1, 1'b0, 1'b0);
        run_acc(8'h01, 1'b0, 16'h0400, 8'h3C, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ext_only();
        ext_only = 1'b1;
        run_acc(8'h12, 1'b0, 16'h0020, 8'hC7, 1'b0, 1'b0, 1'b0);
        run_acc(8'h00, 1'b1, 16'h03FF, 8'h18, 1'b0, 1'b0, 1'b0);
        ext_only = 1'b0;
    endtask

    task automatic t_busy();
        ext_only = 1'b1;
        run_acc(8'h37, 1'b1, 16'h5A5A, 8'h99, 1'b0, 1'b1, 1'b1);
        check(cfg_rd_data == 8'h00, "R12 mid-cycle cfg write lands", int'(cfg_rd_data), 0);
        ext_only = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_cfg();
        t_mux_min();
        t_mux_max();
        t_mux_mix();
        t_nomux();
        t_nomux_rd();
        t_local();
        t_ext_only();
        t_busy();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!ended) begin
            ended = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule